// File: doc/BRIEF.md
# External Interrupt Request Flag Bank

This block keeps one pending flag for each of sixteen external interrupt request lines and presents them together as a single 16-bit status word. Each line has two candidate input pins. A per-line select input picks which pin feeds the line. The chosen pin goes through a two-flop synchronizer. It is then sensed in one of four ways: low level, falling edge, rising edge or either edge. When the chosen condition is seen, the flag for that line rises.

Flags are cleared in three ways:
- Software must first read the status word with the bit at 1, then write that bit as 0.
- The exception acknowledge strobe for a line clears its flag. In low-level mode this happens only while the synchronized pin is high.
- A transfer-controller acknowledge strobe clears the flag, unless the per-line keep bit for that controller is 1.

If a new set event arrives in the same cycle as any clear, the set wins. A line in low-level mode therefore stays pending for as long as its pin is held low.

Top module: `irq_flag_bank`

## Requirements
- R1: After reset all sixteen flags are 0, and the read-data port always shows the current flags, with bit n holding line n.
- R2: With sense code 2'b00 (low level, field bits [2n+1:2n] of senseMode), the flag of line n sets in every cycle in which the synchronized pin is low. The flag is visible three clock edges after the pin falls.
- R3: Sense code 2'b01 sets the flag on a falling edge, 2'b10 on a rising edge and 2'b11 on either edge of the synchronized pin. The synchronizer resets to the high level, so no edge is seen out of reset.
- R4: A bus write of 1 to a flag bit never changes that flag.
- R5: A bus write of 0 clears a flag only if that bit was read as 1 by an earlier bus read since the last bus write. Every bus write disarms all bits, so a second write of 0 without a new read leaves a set flag unchanged.
- R6: An exception acknowledge for line n clears its flag in all three edge modes. In low-level mode it clears the flag only when the synchronized pin is high.
- R7: A transfer acknowledge for line n clears its flag when xferKeep bit n is 0 and leaves it set when that bit is 1.
- R8: pinSelect bit n at 0 routes pinPrimary bit n to line n. At 1 it routes pinAlternate bit n, and the unselected pin has no effect.
- R9: A set event and a clear in the same cycle leave the flag at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busRd | input | 1 | Read strobe for the status word |
| busWr | input | 1 | Write strobe for the status word |
| busWdata | input | 16 | Write data; 0 bits request a clear |
| busRdata | output | 16 | Current flags |
| pinPrimary | input | 16 | First candidate pin per line |
| pinAlternate | input | 16 | Second candidate pin per line |
| pinSelect | input | 16 | Per-line pin choice (0 primary, 1 alternate) |
| senseMode | input | 32 | Two-bit sense code per line |
| excAck | input | 16 | Exception acknowledge, one strobe per line |
| xferAck | input | 16 | Transfer-controller acknowledge, one strobe per line |
| xferKeep | input | 16 | Per-line bit that blocks the transfer-acknowledge clear |
| flags | output | 16 | Pending flags |

## Verification
Pin changes go through two synchronizer flops before the flag register, so a pin driven between edges shows in the flags three rising edges later. Bus writes and acknowledge strobes act on the very next edge. A read arms its bits at the edge where it is sampled, so the following write can clear them. The bench drives inputs on falling edges and compares against its own model, which moves forward one step per rising edge, at every following falling edge. Directed checks wait at least the full three-edge latency before they read a pending mask.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;
  localparam int LINES = 16;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_FALL = 2'b01,
    SENSE_RISE = 2'b10,
    SENSE_BOTH = 2'b11
  } sense_e;

  typedef struct packed {
    logic [LINES-1:0] swClr;
    logic [LINES-1:0] excClr;
    logic [LINES-1:0] xferClr;
  } flagStrobe_t;
endpackage

// File: rtl/irq_flag_dp.sv
module irq_flag_dp
  import irq_flag_pkg::*;
#(
  parameter int SYNC_DEPTH = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [LINES-1:0]   pinPrimary,
  input  logic [LINES-1:0]   pinAlternate,
  input  logic [LINES-1:0]   pinSelect,
  input  logic [2*LINES-1:0] senseMode,
  input  flagStrobe_t        strobes,
  output logic [LINES-1:0]   flags,
  output logic [LINES-1:0]   syncLevel
);
  localparam int TOP = SYNC_DEPTH - 1;

  logic [LINES-1:0] prevLevel;
  logic [LINES-1:0] setEvent;
  logic [LINES-1:0] clearAny;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic [TOP:0] syncPipe;
    logic         routedPin;
    sense_e       mode;

    assign routedPin = pinSelect[i] ? pinAlternate[i] : pinPrimary[i];
    assign mode      = sense_e'(senseMode[2*i +: 2]);

    if (SYNC_DEPTH > 1) begin : g_deep
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncPipe <= '1;
        else       syncPipe <= {syncPipe[TOP-1:0], routedPin};
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncPipe <= '1;
        else       syncPipe <= routedPin;
      end
    end

    assign syncLevel[i] = syncPipe[TOP];

    always_comb begin
      unique case (mode)
        SENSE_LOW:  setEvent[i] = ~syncLevel[i];
        SENSE_FALL: setEvent[i] = prevLevel[i] & ~syncLevel[i];
        SENSE_RISE: setEvent[i] = ~prevLevel[i] & syncLevel[i];
        default:    setEvent[i] = prevLevel[i] ^ syncLevel[i];
      endcase
    end
  end

  assign clearAny = strobes.swClr | strobes.excClr | strobes.xferClr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevLevel <= '1;
      flags     <= '0;
    end else begin
      prevLevel <= syncLevel;
      flags     <= setEvent | (flags & ~clearAny);
    end
  end
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irq_flag_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               busRd,
  input  logic               busWr,
  input  logic [LINES-1:0]   busWdata,
  input  logic [LINES-1:0]   flags,
  input  logic [LINES-1:0]   syncLevel,
  input  logic [2*LINES-1:0] senseMode,
  input  logic [LINES-1:0]   excAck,
  input  logic [LINES-1:0]   xferAck,
  input  logic [LINES-1:0]   xferKeep,
  output flagStrobe_t        strobes
);
  logic [LINES-1:0] armed;
  logic [LINES-1:0] levelMode;

  for (genvar i = 0; i < LINES; i++) begin : g_mode
    assign levelMode[i] = (sense_e'(senseMode[2*i +: 2]) == SENSE_LOW);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      armed <= '0;
    else if (busWr) armed <= '0;
    else if (busRd) armed <= armed | flags;
  end

  always_comb begin
    strobes.swClr   = busWr ? (armed & ~busWdata) : '0;
    strobes.excClr  = excAck & (~levelMode | syncLevel);
    strobes.xferClr = xferAck & ~xferKeep;
  end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import irq_flag_pkg::*;
#(
  parameter int SYNC_DEPTH = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busRd,
  input  logic               busWr,
  input  logic [LINES-1:0]   busWdata,
  output logic [LINES-1:0]   busRdata,
  input  logic [LINES-1:0]   pinPrimary,
  input  logic [LINES-1:0]   pinAlternate,
  input  logic [LINES-1:0]   pinSelect,
  input  logic [2*LINES-1:0] senseMode,
  input  logic [LINES-1:0]   excAck,
  input  logic [LINES-1:0]   xferAck,
  input  logic [LINES-1:0]   xferKeep,
  output logic [LINES-1:0]   flags
);
  flagStrobe_t      strobes;
  logic [LINES-1:0] syncLevel;

  irq_flag_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busRd     (busRd),
    .busWr     (busWr),
    .busWdata  (busWdata),
    .flags     (flags),
    .syncLevel (syncLevel),
    .senseMode (senseMode),
    .excAck    (excAck),
    .xferAck   (xferAck),
    .xferKeep  (xferKeep),
    .strobes   (strobes)
  );

  irq_flag_dp #(.SYNC_DEPTH(SYNC_DEPTH)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .pinPrimary   (pinPrimary),
    .pinAlternate (pinAlternate),
    .pinSelect    (pinSelect),
    .senseMode    (senseMode),
    .strobes      (strobes),
    .flags        (flags),
    .syncLevel    (syncLevel)
  );

  assign busRdata = flags;
endmodule

// File: rtl/irq_flag_chk.sv
module irq_flag_chk
  import irq_flag_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               busWr,
  input logic [LINES-1:0]   busWdata,
  input logic [LINES-1:0]   busRdata,
  input logic [2*LINES-1:0] senseMode,
  input logic [LINES-1:0]   excAck,
  input logic [LINES-1:0]   xferAck,
  input logic [LINES-1:0]   xferKeep,
  input logic [LINES-1:0]   syncLevel,
  input logic [LINES-1:0]   flags
);
  logic [LINES-1:0] lowMask;
  logic [LINES-1:0] prevFlags;
  logic [LINES-1:0] prevCause;
  logic [LINES-1:0] prevLowSet;
  logic [LINES-1:0] prevLevelHigh;

  for (genvar i = 0; i < LINES; i++) begin : g_low
    assign lowMask[i] = (senseMode[2*i +: 2] == 2'b00);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevFlags     <= '0;
      prevCause     <= '0;
      prevLowSet    <= '0;
      prevLevelHigh <= '0;
    end else begin
      prevFlags     <= flags;
      prevCause     <= (busWr ? ~busWdata : '0) | excAck | (xferAck & ~xferKeep);
      prevLowSet    <= lowMask & ~syncLevel;
      prevLevelHigh <= lowMask & syncLevel;
    end
  end

  // R1: reset empties the flags, and the read port mirrors them
  a_r1_reset_clear: assert property (@(posedge clk) !rstN |=> (flags == '0));
  a_r1_read_mirror: assert property (@(posedge clk) disable iff (!rstN) busRdata == flags);

  // R4 R7: a flag falls only when a write of 0, an exception acknowledge
  // or an unblocked transfer acknowledge came in the cycle before
  a_r4_fall_has_cause: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((prevFlags & ~flags & ~prevCause) == '0));

  // R2 R9: a low synchronized level in level mode leaves the flag at 1 in the next cycle
  a_r9_low_reasserts: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((prevLowSet & ~flags) == '0));

  // R2: in level mode a flag never rises while the synchronized pin was high
  a_r2_no_rise_high: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((~prevFlags & flags & prevLevelHigh) == '0));
endmodule

bind irq_flag_bank irq_flag_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busWr     (busWr),
  .busWdata  (busWdata),
  .busRdata  (busRdata),
  .senseMode (senseMode),
  .excAck    (excAck),
  .xferAck   (xferAck),
  .xferKeep  (xferKeep),
  .syncLevel (syncLevel),
  .flags     (flags)
);

// File: tb/test_irq_flag_bank.sv
`timescale 1ns/1ps
module test_irq_flag_bank;
  localparam int N = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busRd = 1'b0, busWr = 1'b0;
  logic [N-1:0] busWdata = '1;
  logic [N-1:0] busRdata, flags;
  logic [N-1:0] pinPrimary = '1, pinAlternate = '1, pinSelect = '0;
  logic [2*N-1:0] senseMode = {N{2'b01}};
  logic [N-1:0] excAck = '0, xferAck = '0, xferKeep = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_flag_bank i_irq_flag_bank (
    .clk(clk), .rstN(rstN), .busRd(busRd), .busWr(busWr), .busWdata(busWdata),
    .busRdata(busRdata), .pinPrimary(pinPrimary), .pinAlternate(pinAlternate),
    .pinSelect(pinSelect), .senseMode(senseMode), .excAck(excAck),
    .xferAck(xferAck), .xferKeep(xferKeep), .flags(flags)
  );

  // behavioural reference, one step per rising edge
  bit mFlag [N];
  bit mArm  [N];
  bit mS1 [N];
  bit mS2 [N];
  bit mPrev [N];

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < N; i++) begin
        mFlag[i] = 0; mArm[i] = 0; mS1[i] = 1; mS2[i] = 1; mPrev[i] = 1;
      end
    end else begin
      bit nf [N];
      for (int i = 0; i < N; i++) begin
        int m;
        bit lvl, pv, setEv, clr;
        m = int'(senseMode[2*i +: 2]);
        lvl = mS2[i];
        pv = mPrev[i];
        if (m == 0)      setEv = !lvl;
        else if (m == 1) setEv = pv && !lvl;
        else if (m == 2) setEv = !pv && lvl;
        else             setEv = pv != lvl;
        clr = (busWr && !busWdata[i] && mArm[i]) ||
              (excAck[i] && (m != 0 || lvl)) ||
              (xferAck[i] && !xferKeep[i]);
        nf[i] = setEv || (mFlag[i] && !clr);
      end
      for (int i = 0; i < N; i++) begin
        if (busWr)      mArm[i] = 0;
        else if (busRd) mArm[i] = mArm[i] || mFlag[i];
        mPrev[i] = mS2[i];
        mS2[i] = mS1[i];
        mS1[i] = pinSelect[i] ? pinAlternate[i] : pinPrimary[i];
        mFlag[i] = nf[i];
      end
    end
  end

  function automatic logic [N-1:0] modelWord();
    logic [N-1:0] w;
    for (int i = 0; i < N; i++) w[i] = mFlag[i];
    return w;
  endfunction

  // model compare on every cycle (R1 R2 R3 R5 R6 R7 R8 R9)
  always @(negedge clk) begin
    if (rstN && !done) begin
      checks++;
      if (flags !== modelWord() || busRdata !== flags) begin
        errors++;
        $display("FAIL model compare R1 R2 R3: flags=%h rdata=%h expected=%h at %0t",
                 flags, busRdata, modelWord(), $time);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expectBit(input string tag, input int line, input bit exp);
    checks++;
    if (flags[line] !== exp) begin
      errors++;
      $display("FAIL %s line %0d: actual=%b expected=%b", tag, line, flags[line], exp);
    end
  endtask

  task automatic setMode(input int line, input logic [1:0] code);
    senseMode[2*line +: 2] = code;
  endtask

  task automatic readWord();
    busRd = 1'b1; cyc(1); busRd = 1'b0;
  endtask

  task automatic writeWord(input logic [N-1:0] d);
    busWdata = d; busWr = 1'b1; cyc(1); busWr = 1'b0; busWdata = '1;
  endtask

  task automatic pulseExc(input int line);
    excAck[line] = 1'b1; cyc(1); excAck[line] = 1'b0;
  endtask

  initial begin
    cyc(3);
    checks++;
    if (flags !== '0) begin
      errors++;
      $display("FAIL R1 reset: actual=%h expected=0000", flags);
    end
    rstN = 1'b1;
    cyc(5);
    checks++;
    if (flags !== '0) begin
      errors++;
      $display("FAIL R3 no edge after reset: actual=%h expected=0000", flags);
    end

    // R3 falling edge on line 0, three-edge latency
    pinPrimary[0] = 1'b0;
    cyc(2); expectBit("R2 latency not yet", 0, 1'b0);
    cyc(1); expectBit("R3 falling set", 0, 1'b1);

    // R4 writing 1 keeps the flag
    writeWord('1); cyc(1); expectBit("R4 write one", 0, 1'b1);
    // R5 write 0 without an armed read does nothing
    writeWord('0); cyc(1); expectBit("R5 unarmed write", 0, 1'b1);
    // R5 read then write 0 clears
    readWord(); writeWord(16'hFFFE); expectBit("R5 armed clear", 0, 1'b0);
    // R5 arm dropped after a write: a new set needs a new read
    pinPrimary[0] = 1'b1; cyc(4); pinPrimary[0] = 1'b0; cyc(4);
    expectBit("R3 falling again", 0, 1'b1);
    readWord(); writeWord('1); writeWord(16'hFFFE); cyc(1);
    expectBit("R5 disarmed by write", 0, 1'b1);
    pulseExc(0); expectBit("R6 edge mode exc clear", 0, 1'b0);

    // R3 rising on line 1
    setMode(1, 2'b10);
    pinPrimary[1] = 1'b0; cyc(5); expectBit("R3 rising ignores fall", 1, 1'b0);
    pinPrimary[1] = 1'b1; cyc(4); expectBit("R3 rising set", 1, 1'b1);
    pulseExc(1); expectBit("R6 rising exc clear", 1, 1'b0);

    // R2 R6 R9 low level on line 2
    setMode(2, 2'b00);
    pinPrimary[2] = 1'b0; cyc(4); expectBit("R2 low level set", 2, 1'b1);
    pulseExc(2); cyc(1); expectBit("R6 low exc while low", 2, 1'b1);
    readWord(); writeWord(16'hFFFB); cyc(1); expectBit("R9 low reasserts", 2, 1'b1);
    pinPrimary[2] = 1'b1; cyc(4); expectBit("R2 held after release", 2, 1'b1);
    pulseExc(2); cyc(1); expectBit("R6 low exc while high", 2, 1'b0);

    // R3 both edges on line 3
    setMode(3, 2'b11);
    pinPrimary[3] = 1'b0; cyc(4); expectBit("R3 both fall", 3, 1'b1);
    pulseExc(3); expectBit("R6 both clear", 3, 1'b0);
    pinPrimary[3] = 1'b1; cyc(4); expectBit("R3 both rise", 3, 1'b1);
    pulseExc(3);

    // R7 transfer acknowledge on line 4
    pinPrimary[4] = 1'b0; cyc(4); expectBit("R3 line4 set", 4, 1'b1);
    xferKeep[4] = 1'b1; xferAck[4] = 1'b1; cyc(1); xferAck[4] = 1'b0;
    expectBit("R7 keep blocks clear", 4, 1'b1);
    xferKeep[4] = 1'b0; xferAck[4] = 1'b1; cyc(1); xferAck[4] = 1'b0;
    expectBit("R7 transfer clear", 4, 1'b0);

    // R8 pin selection on line 5
    pinSelect[5] = 1'b1; cyc(4);
    pinPrimary[5] = 1'b0; cyc(5); expectBit("R8 primary ignored", 5, 1'b0);
    pinAlternate[5] = 1'b0; cyc(4); expectBit("R8 alternate used", 5, 1'b1);
    pulseExc(5);
    pinPrimary[5] = 1'b1; pinSelect[5] = 1'b0; cyc(4);
    pinPrimary[5] = 1'b0; cyc(4); expectBit("R8 primary used", 5, 1'b1);

    // R9 set wins: exception acknowledge at the same edge as a new fall on line 6
    pinPrimary[6] = 1'b0; cyc(4); expectBit("R3 line6 set", 6, 1'b1);
    pinPrimary[6] = 1'b1; cyc(4);
    pinPrimary[6] = 1'b0; cyc(2);
    excAck[6] = 1'b1; cyc(1); excAck[6] = 1'b0;
    expectBit("R9 set beats clear", 6, 1'b1);

    cyc(2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule